// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the transmit engine of a descriptor-ring DMA. Software builds a ring of 32-byte descriptors in a descriptor RAM and hands each one to hardware by clearing its ownership bit. The fetcher walks the ring from a programmed base address. For each descriptor that hardware owns, it reads the configuration word, the buffer pointer and the port-map word. It then presents a frame request carrying the buffer address, length, destination port map and offload flags.

When the frame consumer acknowledges the request, the fetcher sets the ownership bit in the descriptor's first configuration word, which returns the descriptor to software. It raises a completion pulse if software asked for one, then moves to the next descriptor. An end-of-ring flag in the descriptor, not a size register, sends the pointer back to the base. Fetching runs only while polling is enabled and suspend is clear. A descriptor still owned by software is polled again after a programmable gap. Payload movement and checksum computation belong to other blocks.

Descriptor layout, as byte offsets from the descriptor pointer:
- offset 0: buffer pointer
- offset 4: configuration word A
- offset 8: configuration word B

Configuration word A carries:
- bit 31: owned by software
- bit 30: end of ring
- bit 29: first segment
- bit 28: last segment
- bit 27: completion requested
- bit 26: force route
- bit 25: force priority
- bits 24:22: priority
- bits 18:16: checksum requests (IP, UDP, TCP)
- bits 15:0: length

Configuration word B carries the port map in bits 21:17.

Top module: `tx_ring_fetcher`

## Requirements
- R1: Out of reset frmValid, memRe, memWe and donePulse are 0 and curPtr is 0.
- R2: A ptrInit pulse loads curPtr from ringBase on the next clock edge.
- R3: A new descriptor fetch is started only while pollEn is 1 and suspend is 0. A fetch starts with a read at curPtr+4. With pollEn at 0, or suspend at 1, no memory read is issued while the block is idle.
- R4: If bit 31 of word A is 1, the descriptor is owned by software. It is not presented, and the read of word A at that same address is repeated pollGap+3 cycles after the previous read.
- R5: For a descriptor with bit 31 of word A at 0, the frame outputs carry the following, and they hold steady while frmValid is 1 and frmAck is 0:
  - frmAddr: the word at offset 0
  - frmLen: word A bits 15:0
  - frmCsum: word A bits 18:16
  - frmPrio: word A bits 24:22
  - frmForcePrio: word A bit 25
  - frmForceRoute: word A bit 26
  - frmLast: word A bit 28
  - frmFirst: word A bit 29
  - frmPortMap: word B bits 21:17
- R6: In the cycle that frmValid and frmAck are both 1, the block writes word A back at curPtr+4. The written value is the word as read with only bit 31 set, and every other bit is unchanged.
- R7: After the acknowledge, curPtr reloads from ringBase if word A bit 30 was set. Otherwise curPtr advances by 32.
- R8: donePulse is high for exactly one cycle, in the cycle after the acknowledge, and only when word A bit 27 was set.
- R9: Raising suspend while a frame is presented does not withdraw the frame. After that frame is acknowledged, no further read is issued until suspend clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| ringBase | input | ADDR_W | ring base byte address |
| ptrInit | input | 1 | load current pointer from ringBase |
| pollEn | input | 1 | allow fetching |
| suspend | input | 1 | hold off new fetches |
| pollGap | input | GAP_W | idle cycles before re-polling a software-owned descriptor |
| memAddr | output | ADDR_W | descriptor RAM byte address |
| memRe | output | 1 | RAM read, data valid the next cycle |
| memWe | output | 1 | RAM write |
| memWdata | output | 32 | RAM write data |
| memRdata | input | 32 | RAM read data |
| frmValid | output | 1 | frame request valid |
| frmAck | input | 1 | consumer takes the frame |
| frmAddr | output | 32 | buffer address |
| frmLen | output | 16 | segment length |
| frmPortMap | output | PMAP_W | destination port map |
| frmCsum | output | 3 | checksum requests {IP,UDP,TCP} |
| frmPrio | output | 3 | priority |
| frmForcePrio | output | 1 | force priority |
| frmForceRoute | output | 1 | force route |
| frmFirst | output | 1 | first segment |
| frmLast | output | 1 | last segment |
| curPtr | output | ADDR_W | current descriptor pointer |
| donePulse | output | 1 | completion pulse |

## Verification
The bench builds the block with ADDR_W of 8 and GAP_W of 4. The 8-bit width keeps the whole ring inside a 64-word RAM model, and the four-descriptor ring makes the end-of-ring wrap back to the base reachable within a handful of frames. A pollGap of 5 keeps the re-poll interval short enough to measure to the exact cycle. The descriptor vectors set bits in word B outside the port map, and use the maximum length, so that field extraction errors show up.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_BYTES  = 32;
  localparam int OFF_BUF     = 0;
  localparam int OFF_CFGA    = 4;
  localparam int OFF_CFGB    = 8;
  localparam int OWN_BIT     = 31;
  localparam int EOR_BIT     = 30;
  localparam int FIRST_BIT   = 29;
  localparam int LAST_BIT    = 28;
  localparam int IRQ_BIT     = 27;
  localparam int FROUTE_BIT  = 26;
  localparam int FPRIO_BIT   = 25;
  localparam int PRIO_LSB    = 22;
  localparam int CSUM_LSB    = 16;
  localparam int PMAP_LSB    = 17;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_RDP, ST_RDB, ST_SEND, ST_WAIT
  } txrState_e;

  typedef struct packed {
    logic rdCfgA;
    logic rdBuf;
    logic rdCfgB;
    logic capCfgA;
    logic capBuf;
    logic capCfgB;
    logic retire;
  } txrStrobe_t;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pollEn,
  input  logic             suspend,
  input  logic [GAP_W-1:0] pollGap,
  input  logic             ownedBySw,
  input  logic             frmAck,
  output txrStrobe_t       stb,
  output logic             presenting
);
  txrState_e state, stateNxt;
  logic [GAP_W-1:0] waitCnt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (pollEn && !suspend) begin
        stb.rdCfgA = 1'b1;
        stateNxt   = ST_CHK;
      end
      ST_CHK: if (ownedBySw) begin
        stateNxt = ST_WAIT;
      end else begin
        stb.capCfgA = 1'b1;
        stb.rdBuf   = 1'b1;
        stateNxt    = ST_RDP;
      end
      ST_RDP: begin
        stb.capBuf = 1'b1;
        stb.rdCfgB = 1'b1;
        stateNxt   = ST_RDB;
      end
      ST_RDB: begin
        stb.capCfgB = 1'b1;
        stateNxt    = ST_SEND;
      end
      ST_SEND: if (frmAck) begin
        stb.retire = 1'b1;
        stateNxt   = ST_IDLE;
      end
      ST_WAIT: if (waitCnt == '0) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_CHK && ownedBySw) waitCnt <= pollGap;
      else if (state == ST_WAIT && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
    end
  end

  assign presenting = (state == ST_SEND);
endmodule

// File: rtl/txr_dpath.sv
module txr_dpath
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PMAP_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  txrStrobe_t        stb,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              ptrInit,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [31:0]       memWdata,
  output logic [ADDR_W-1:0] curPtr,
  output logic [31:0]       frmAddr,
  output logic [15:0]       frmLen,
  output logic [PMAP_W-1:0] frmPortMap,
  output logic [2:0]        frmCsum,
  output logic [2:0]        frmPrio,
  output logic              frmForcePrio,
  output logic              frmForceRoute,
  output logic              frmFirst,
  output logic              frmLast,
  output logic              donePulse
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] ptrQ, offset;
  logic [31:0] cfgAQ, bufQ, cfgBQ;
  logic doneQ;

  always_comb begin
    if (stb.rdBuf)       offset = ADDR_W'(OFF_BUF);
    else if (stb.rdCfgB) offset = ADDR_W'(OFF_CFGB);
    else                 offset = ADDR_W'(OFF_CFGA);
  end

  assign memAddr  = ptrQ + offset;
  assign memRe    = stb.rdCfgA | stb.rdBuf | stb.rdCfgB;
  assign memWe    = stb.retire;
  assign memWdata = cfgAQ | (32'd1 << OWN_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      cfgAQ <= '0;
      bufQ  <= '0;
      cfgBQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (stb.capCfgA) cfgAQ <= memRdata;
      if (stb.capBuf)  bufQ  <= memRdata;
      if (stb.capCfgB) cfgBQ <= memRdata;
      doneQ <= stb.retire & cfgAQ[IRQ_BIT];
      if (ptrInit)         ptrQ <= ringBase;
      else if (stb.retire) ptrQ <= cfgAQ[EOR_BIT] ? ringBase : ptrQ + STEP;
    end
  end

  assign curPtr        = ptrQ;
  assign frmAddr       = bufQ;
  assign frmLen        = cfgAQ[15:0];
  assign frmPortMap    = cfgBQ[PMAP_LSB +: PMAP_W];
  assign frmCsum       = cfgAQ[CSUM_LSB +: 3];
  assign frmPrio       = cfgAQ[PRIO_LSB +: 3];
  assign frmForcePrio  = cfgAQ[FPRIO_BIT];
  assign frmForceRoute = cfgAQ[FROUTE_BIT];
  assign frmFirst      = cfgAQ[FIRST_BIT];
  assign frmLast       = cfgAQ[LAST_BIT];
  assign donePulse     = doneQ;
endmodule

// File: rtl/tx_ring_fetcher.sv
module tx_ring_fetcher
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GAP_W  = 8,
  parameter int PMAP_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              ptrInit,
  input  logic              pollEn,
  input  logic              suspend,
  input  logic [GAP_W-1:0]  pollGap,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              frmValid,
  input  logic              frmAck,
  output logic [31:0]       frmAddr,
  output logic [15:0]       frmLen,
  output logic [PMAP_W-1:0] frmPortMap,
  output logic [2:0]        frmCsum,
  output logic [2:0]        frmPrio,
  output logic              frmForcePrio,
  output logic              frmForceRoute,
  output logic              frmFirst,
  output logic              frmLast,
  output logic [ADDR_W-1:0] curPtr,
  output logic              donePulse
);
  txrStrobe_t stb;

  txr_ctrl #(.GAP_W(GAP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pollEn(pollEn), .suspend(suspend),
    .pollGap(pollGap), .ownedBySw(memRdata[OWN_BIT]), .frmAck(frmAck),
    .stb(stb), .presenting(frmValid)
  );

  txr_dpath #(.ADDR_W(ADDR_W), .PMAP_W(PMAP_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ringBase(ringBase), .ptrInit(ptrInit),
    .memRdata(memRdata), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .curPtr(curPtr), .frmAddr(frmAddr), .frmLen(frmLen),
    .frmPortMap(frmPortMap), .frmCsum(frmCsum), .frmPrio(frmPrio),
    .frmForcePrio(frmForcePrio), .frmForceRoute(frmForceRoute),
    .frmFirst(frmFirst), .frmLast(frmLast), .donePulse(donePulse)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ringBase,
  input logic              ptrInit,
  input logic              pollEn,
  input logic              suspend,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRe,
  input logic              memWe,
  input logic [31:0]       memWdata,
  input logic              frmValid,
  input logic              frmAck,
  input logic [31:0]       frmAddr,
  input logic [15:0]       frmLen,
  input logic [ADDR_W-1:0] curPtr,
  input logic              donePulse
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] OFFA = ADDR_W'(4);

  assert_fetch_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && memAddr == curPtr + OFFA) |-> (pollEn && !suspend));

  assert_frame_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmAck) |=> (frmValid && $stable(frmAddr) && $stable(frmLen)));

  assert_wb_on_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (frmValid && frmAck && memWdata[31] && !memRe && memAddr == curPtr + OFFA));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frmValid && frmAck) && !$past(ptrInit)) |->
      (curPtr == $past(curPtr) + STEP || curPtr == $past(ringBase)));

  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(frmValid && frmAck));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
endmodule

bind tx_ring_fetcher txr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .ringBase(ringBase), .ptrInit(ptrInit),
  .pollEn(pollEn), .suspend(suspend), .memAddr(memAddr), .memRe(memRe),
  .memWe(memWe), .memWdata(memWdata), .frmValid(frmValid), .frmAck(frmAck),
  .frmAddr(frmAddr), .frmLen(frmLen), .curPtr(curPtr), .donePulse(donePulse)
);

// File: tb/tx_ring_fetcher_tb_top.sv
module tx_ring_fetcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int GAP_W  = 4;
  localparam int PMAP_W = 5;
  localparam logic [7:0] BASE = 8'h40;
  localparam int NVEC = 4;
  // {buffer pointer, word A, word B}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h1000_0000, 32'h3947_05EA, 32'h0002_0000},
    {32'hDEAD_BEE0, 32'h0600_0040, 32'h0020_0003},
    {32'h0000_0004, 32'h0001_FFFF, 32'hFFFE_0000},
    {32'h1234_5678, 32'h7800_0100, 32'h0008_0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] ringBase = '0;
  logic ptrInit = 1'b0, pollEn = 1'b0, suspend = 1'b0, frmAck = 1'b0;
  logic [GAP_W-1:0] pollGap = 4'd5;
  logic [ADDR_W-1:0] memAddr, curPtr;
  logic memRe, memWe, frmValid, donePulse;
  logic [31:0] memWdata, frmAddr;
  logic [31:0] memRdata = '0;
  logic [15:0] frmLen;
  logic [PMAP_W-1:0] frmPortMap;
  logic [2:0] frmCsum, frmPrio;
  logic frmForcePrio, frmForceRoute, frmFirst, frmLast;

  logic [31:0] mem [64];
  logic hostWe = 1'b0;
  logic [5:0] hostIdx = '0;
  logic [31:0] hostData = '0;

  int cycle = 0, readCnt = 0, lastRd = -1, rdGap = -1, frameRises = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ring_fetcher #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .PMAP_W(PMAP_W)) dut_i (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .ptrInit(ptrInit),
    .pollEn(pollEn), .suspend(suspend), .pollGap(pollGap),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .frmValid(frmValid), .frmAck(frmAck),
    .frmAddr(frmAddr), .frmLen(frmLen), .frmPortMap(frmPortMap),
    .frmCsum(frmCsum), .frmPrio(frmPrio), .frmForcePrio(frmForcePrio),
    .frmForceRoute(frmForceRoute), .frmFirst(frmFirst), .frmLast(frmLast),
    .curPtr(curPtr), .donePulse(donePulse)
  );

  logic prevValid = 1'b0;
  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (hostWe) mem[hostIdx] <= hostData;
    else if (memWe) mem[memAddr[7:2]] <= memWdata;
    if (memRe) begin
      memRdata <= mem[memAddr[7:2]];
      readCnt  <= readCnt + 1;
      if (memAddr == BASE + 8'd4) begin
        if (lastRd >= 0) rdGap <= cycle - lastRd;
        lastRd <= cycle;
      end
    end
    prevValid <= frmValid;
    if (frmValid && !prevValid) frameRises <= frameRises + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    hostWe = 1'b1; hostIdx = addr[7:2]; hostData = data;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic waitFrame(output bit seen);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (frmValid) begin seen = 1; break; end
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycle);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!frmValid && !memRe && !memWe && !donePulse, "R1 outputs idle in reset",
          {frmValid, memRe, memWe, donePulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(curPtr == 0, "R1 curPtr after reset", curPtr, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] d;
      d = BASE + 8'(32 * i);
      hostWrite(d,        VEC[i][95:64]);
      hostWrite(d + 8'd4, VEC[i][63:32]);
      hostWrite(d + 8'd8, VEC[i][31:0]);
    end

    // R2 pointer init
    ringBase = BASE;
    @(negedge clk); ptrInit = 1'b1;
    @(negedge clk); ptrInit = 1'b0;
    check(curPtr == BASE, "R2 ptrInit loads base", curPtr, BASE);

    // R3 no reads while polling disabled
    begin
      int r0;
      r0 = readCnt;
      repeat (8) @(negedge clk);
      check(readCnt == r0, "R3 no reads with pollEn=0", readCnt, r0);
      suspend = 1'b1; pollEn = 1'b1;
      repeat (8) @(negedge clk);
      check(readCnt == r0, "R3 no reads while suspended", readCnt, r0);
      suspend = 1'b0;
    end

    // Vector walk: R5, R6, R7, R8
    for (int i = 0; i < NVEC; i++) begin
      bit seen;
      logic [31:0] b, a, c;
      logic [7:0] d, expPtr;
      b = VEC[i][95:64]; a = VEC[i][63:32]; c = VEC[i][31:0];
      d = BASE + 8'(32 * i);
      expPtr = a[30] ? BASE : d + 8'd32;
      waitFrame(seen);
      check(seen, "R5 frame presented", seen, 1);
      check(frmAddr == b, "R5 buffer address", frmAddr, b);
      check(frmLen == a[15:0], "R5 length", frmLen, a[15:0]);
      check(frmPortMap == c[21:17], "R5 port map", frmPortMap, c[21:17]);
      check({frmCsum, frmPrio, frmForcePrio, frmForceRoute, frmLast, frmFirst} ==
            {a[18:16], a[24:22], a[25], a[26], a[28], a[29]}, "R5 flags",
            {frmCsum, frmPrio, frmForcePrio, frmForceRoute, frmLast, frmFirst},
            {a[18:16], a[24:22], a[25], a[26], a[28], a[29]});
      frmAck = 1'b1;
      @(negedge clk);
      frmAck = 1'b0;
      check(mem[d[7:2] + 6'd1] == (a | 32'h8000_0000), "R6 writeback sets only ownership",
            mem[d[7:2] + 6'd1], a | 32'h8000_0000);
      check(curPtr == expPtr, "R7 pointer advance or wrap", curPtr, expPtr);
      check(donePulse == a[27], "R8 completion pulse", donePulse, a[27]);
      @(negedge clk);
      check(!donePulse, "R8 pulse is single cycle", donePulse, 0);
    end

    // R4: descriptor 0 now software-owned; re-poll interval
    begin
      int f0;
      f0 = frameRises;
      repeat (40) @(negedge clk);
      check(frameRises == f0 && !frmValid, "R4 software-owned not presented", frameRises, f0);
      check(rdGap == int'(pollGap) + 3, "R4 re-poll interval", rdGap, int'(pollGap) + 3);
    end

    // R9: return descriptor 0 to hardware, suspend mid-frame
    begin
      bit seen;
      int r0;
      logic [31:0] a0;
      a0 = VEC[0][63:32];
      hostWrite(BASE + 8'd4, a0);
      waitFrame(seen);
      check(seen, "R9 frame presented after release", seen, 1);
      suspend = 1'b1;
      repeat (4) @(negedge clk);
      check(frmValid && frmAddr == VEC[0][95:64], "R9 frame kept under suspend",
            frmAddr, VEC[0][95:64]);
      frmAck = 1'b1;
      @(negedge clk);
      frmAck = 1'b0;
      check(curPtr == BASE + 8'd32, "R7 pointer after resumed frame", curPtr, BASE + 8'd32);
      r0 = readCnt;
      repeat (10) @(negedge clk);
      check(readCnt == r0, "R9 no fetch while suspended", readCnt, r0);
      suspend = 1'b0;
      repeat (4) @(negedge clk);
      check(readCnt > r0, "R3 fetch resumes after suspend clears", readCnt, r0 + 1);
    end

    finishRun();
  end
endmodule